// File: doc/BRIEF.md
# RS485 Serial Transmitter with Line Guard Time

This block is an asynchronous serial transmitter for a half-duplex RS485 bus. A register-style write port holds four settings (transmit data, line mode, guard time and baud divisor). A single holding register accepts the next character while the current one is shifted out. Each character is sent as a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. Every bit lasts one divisor's worth of clock cycles.

After each stop bit the transmitter can hold the line idle-high for a programmable number of bit periods. In RS485 mode the driver-enable output is the inverse of the transmitter-empty status. That status stays low through the guard period, so the external transceiver keeps driving the bus until the guard time has run out. In normal mode the driver-enable output follows a software-controlled mode bit.

Top module: `rs485_uart_tx`

## Requirements
- R1: After reset txrdy_o=1, txempty_o=1, txd_o=1 and rts_o=0, and the guard time and baud divisor are both 0.
- R2: A write to address 0 loads the character. Address 3 holds the baud divisor N. The first start-bit cycle is the second clock edge after the write cycle. The frame is one low start bit, then data bits 0 through 7, then the stop bit, and each bit lasts exactly N cycles.
- R3: Mode (address 1) bits [4:2] select parity: 0 even, 1 odd, 2 forced 0, 3 forced 1, 4..7 none. With parity, one parity bit lies between bit 7 and the stop bit. With none, the stop bit follows bit 7 directly.
- R4: Address 2 holds a guard count G. After every stop bit the line stays high for G bit periods before the next start bit, or before txempty_o rises.
- R5: A data write clears txrdy_o from the next cycle. txrdy_o returns high one cycle after the held character moves into the shifter. With G=0, a character queued during a frame starts directly after that frame's stop bit.
- R6: txempty_o is low from the cycle after a data write until the last stop bit and its guard period have ended.
- R7: With mode bits [1:0]=1 (RS485), rts_o equals the inverse of txempty_o.
- R8: With mode bits [1:0] not equal to 1, rts_o equals mode bit 5 regardless of activity. txd_o is high whenever no frame is being sent.
- R9: With a divisor of 0, a written character is held and not sent. txd_o stays high, txrdy_o and txempty_o stay low, and the character goes out once a nonzero divisor is written.
- R10: A character queued during a guard period starts only when the full guard has expired. In RS485 mode rts_o stays high without a break between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 data, 1 mode, 2 guard, 3 divisor |
| wr_data_i | input | 16 | Write data |
| txd_o | output | 1 | Serial data out, idles high |
| rts_o | output | 1 | Line driver enable |
| txrdy_o | output | 1 | Holding register free |
| txempty_o | output | 1 | No character held, in flight or in guard |

## Verification
The assertions assume that the mode, guard count and divisor do not change while a character is held or in flight. For example, the guard counter is checked against the live guard setting, and the baud counter against the live divisor. The stimulus only rewrites these registers once txempty_o is high. The one exception is the zero-divisor case: there the divisor is written while a character is held but the engine is still idle, which the assertions allow. Data writes are issued only when the bench expects the holding register to be free or intends a queued character.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_GUARD
  } tx_state_e;

  localparam logic [1:0] LINE_NORMAL = 2'd0;
  localparam logic [1:0] LINE_RS485  = 2'd1;

  localparam logic [2:0] PAR_EVEN = 3'd0;
  localparam logic [2:0] PAR_ODD  = 3'd1;
  localparam logic [2:0] PAR_ZERO = 3'd2;
  localparam logic [2:0] PAR_ONE  = 3'd3;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_TG   = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  localparam int MODE_W = 6;

  typedef struct packed {
    logic       sw_rts;
    logic [2:0] par;
    logic [1:0] line;
  } mode_t;

  function automatic logic par_enabled(input logic [2:0] p);
    return p <= PAR_ONE;
  endfunction

endpackage

// File: rtl/rs485_tx_cfg.sv
module rs485_tx_cfg
  import rs485_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TG_W   = 8,
  parameter int DIV_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output mode_t             mode_o,
  output logic [TG_W-1:0]   tg_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              data_wr_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      tg_o   <= '0;
      div_o  <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_MODE: mode_o <= mode_t'(wr_data_i[MODE_W-1:0]);
        ADDR_TG:   tg_o   <= wr_data_i[TG_W-1:0];
        ADDR_DIV:  div_o  <= wr_data_i[DIV_W-1:0];
        default:   ;
      endcase
    end
  end

  assign data_wr_o = wr_en_i && (wr_addr_i == ADDR_DATA);
  assign data_o    = wr_data_i[DATA_W-1:0];

endmodule

// File: rtl/rs485_baud_gen.sv
module rs485_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             active;

  assign active = run_i && (div_i != '0);
  assign tick_o = active && (cnt_q == div_i - 1'b1);

  // restart at idle so the start bit spans a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!active)    cnt_q <= '0;
    else if (tick_o)     cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && div_i != '0) |-> (cnt_q < div_i))
    else $error("baud counter beyond divisor");

endmodule

// File: rtl/rs485_tx_engine.sv
module rs485_tx_engine
  import rs485_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TG_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  input  logic              tx_en_i,
  input  logic [2:0]        par_mode_i,
  input  logic [TG_W-1:0]   tg_i,
  output logic              busy_o,
  output logic              txd_o,
  output logic              txrdy_o,
  output logic              txempty_o
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] hold_q, shift_q, shift_d;
  logic              hold_vld_q;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [TG_W-1:0]   guard_q, guard_d;
  logic              par_q, par_d, par_en_q, par_en_d;
  logic              frame_end, load, guard_last, par_calc;

  assign guard_last = ((TG_W+1)'(guard_q) + 1'b1) == (TG_W+1)'(tg_i);

  always_comb begin
    unique case (par_mode_i)
      PAR_EVEN: par_calc = ^hold_q;
      PAR_ODD:  par_calc = ~^hold_q;
      PAR_ONE:  par_calc = 1'b1;
      default:  par_calc = 1'b0;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    guard_d   = guard_q;
    shift_d   = shift_q;
    par_d     = par_q;
    par_en_d  = par_en_q;
    frame_end = 1'b0;
    unique case (state_q)
      ST_IDLE: frame_end = 1'b1;
      ST_START: if (tick_i) begin
        state_d = ST_DATA;
        bit_d   = '0;
      end
      ST_DATA: if (tick_i) begin
        shift_d = shift_q >> 1;
        if (bit_q == LAST_BIT) state_d = par_en_q ? ST_PARITY : ST_STOP;
        else                   bit_d   = bit_q + 1'b1;
      end
      ST_PARITY: if (tick_i) state_d = ST_STOP;
      ST_STOP: if (tick_i) begin
        if (tg_i == '0) begin
          frame_end = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          state_d = ST_GUARD;
          guard_d = '0;
        end
      end
      ST_GUARD: if (tick_i) begin
        if (guard_last) begin
          frame_end = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          guard_d = guard_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    load = frame_end && hold_vld_q && tx_en_i;
    if (load) begin
      state_d  = ST_START;
      shift_d  = hold_q;
      par_d    = par_calc;
      par_en_d = par_enabled(par_mode_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      shift_q  <= '0;
      bit_q    <= '0;
      guard_q  <= '0;
      par_q    <= 1'b0;
      par_en_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      shift_q  <= shift_d;
      bit_q    <= bit_d;
      guard_q  <= guard_d;
      par_q    <= par_d;
      par_en_q <= par_en_d;
    end
  end

  // a write in the load cycle refills the holder; load takes the old word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (data_wr_i) begin
      hold_q     <= data_i;
      hold_vld_q <= 1'b1;
    end else if (load) begin
      hold_vld_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START:  txd_o = 1'b0;
      ST_DATA:   txd_o = shift_q[0];
      ST_PARITY: txd_o = par_q;
      default:   txd_o = 1'b1;
    endcase
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign txrdy_o   = !hold_vld_q;
  assign txempty_o = (state_q == ST_IDLE) && !hold_vld_q;

  p_write_clears_rdy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i |=> !txrdy_o)
    else $error("txrdy high after data write");

  p_idle_line_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txempty_o |-> txd_o)
    else $error("line low while empty");

  p_guard_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GUARD) |-> (guard_q < tg_i))
    else $error("guard count overran setting");

  p_freeze_no_div_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> $stable(state_q))
    else $error("state moved with divisor zero");

endmodule

// File: rtl/rs485_uart_tx.sv
module rs485_uart_tx
  import rs485_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TG_W   = 8,
  parameter int DIV_W  = 16,
  localparam int W1    = (DIV_W > TG_W) ? DIV_W : TG_W,
  localparam int W2    = (W1 > DATA_W) ? W1 : DATA_W,
  localparam int REG_W = (W2 > MODE_W) ? W2 : MODE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             txd_o,
  output logic             rts_o,
  output logic             txrdy_o,
  output logic             txempty_o
);

  mode_t             mode;
  logic [TG_W-1:0]   tg;
  logic [DIV_W-1:0]  div;
  logic              data_wr, busy, tick;
  logic [DATA_W-1:0] data;

  rs485_tx_cfg #(
    .DATA_W(DATA_W), .TG_W(TG_W), .DIV_W(DIV_W), .REG_W(REG_W)
  ) cfg_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode),
    .tg_o      (tg),
    .div_o     (div),
    .data_wr_o (data_wr),
    .data_o    (data)
  );

  rs485_baud_gen #(.DIV_W(DIV_W)) baud_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (div),
    .tick_o (tick)
  );

  rs485_tx_engine #(.DATA_W(DATA_W), .TG_W(TG_W)) eng_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_wr_i  (data_wr),
    .data_i     (data),
    .tick_i     (tick),
    .tx_en_i    (div != '0),
    .par_mode_i (mode.par),
    .tg_i       (tg),
    .busy_o     (busy),
    .txd_o      (txd_o),
    .txrdy_o    (txrdy_o),
    .txempty_o  (txempty_o)
  );

  assign rts_o = (mode.line == LINE_RS485) ? !txempty_o : mode.sw_rts;

  p_rts_steady_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode.line == LINE_RS485 && $past(mode.line == LINE_RS485)
      && !txempty_o && $past(!txempty_o)) |-> (rts_o && $past(rts_o)))
    else $error("driver enable dropped while busy");

endmodule

// File: tb/rs485_uart_tx_tb_top.sv
module rs485_uart_tx_tb_top;

  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        txd, rts, txrdy, txempty;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  rs485_uart_tx dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .txd_o     (txd),
    .rts_o     (rts),
    .txrdy_o   (txrdy),
    .txempty_o (txempty)
  );

  typedef struct packed {
    logic [7:0] data;
    logic [2:0] par;
    logic [7:0] tg;
    logic       exp_par;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'hA5, 3'd0, 8'd0, 1'b0},
    '{8'hA5, 3'd1, 8'd0, 1'b1},
    '{8'h3C, 3'd2, 8'd0, 1'b0},
    '{8'h3C, 3'd3, 8'd0, 1'b1},
    '{8'h81, 3'd4, 8'd0, 1'b0},
    '{8'hFF, 3'd0, 8'd4, 1'b0},
    '{8'h01, 3'd1, 8'd2, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mw(input logic [1:0] line, input logic [2:0] par,
                                     input logic sw);
    return {10'd0, sw, par, line};
  endfunction

  function automatic logic fbit(input int k, input logic [7:0] d, input logic pen,
                                input logic pb);
    if (k == 0) return 1'b0;
    if (k <= 8) return d[k-1];
    if (k == 9 && pen) return pb;
    return 1'b1;
  endfunction

  function automatic string ftag(input int k, input logic pen, input int nb);
    if (k <= 8) return "R2";
    if (k == 9 && pen) return "R3";
    if (k < nb) return "R2";
    return "R4";
  endfunction

  // j counts negedges after the clock edge that samples the first data write
  task automatic send(input logic [7:0] a, input logic pa, input logic [7:0] b,
                      input logic pb, input logic two, input int wr_at,
                      input logic pen, input int tg, input logic rs, input logic sw);
    int nb, l, jend;
    nb   = pen ? 11 : 10;
    l    = nb + tg;
    jend = 1 + (two ? 2 * l : l) * DIV;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = {8'd0, a};
    for (int j = 0; j <= jend; j++) begin
      @(negedge clk);
      if (j == 0) wr_en = 1'b0;
      if (two && j == wr_at + 1) wr_en = 1'b0;
      if (j == 0) begin
        chk("R5", txrdy, 0);
        chk("R6", txempty, 0);
      end else begin
        int   kk;
        logic in_a, in_b, busy, etxd;
        string t;
        kk   = (j - 1) / DIV;
        in_a = kk < l;
        in_b = two && !in_a && kk < 2 * l;
        busy = j < jend;
        etxd = in_a ? fbit(kk, a, pen, pa) : (in_b ? fbit(kk - l, b, pen, pb) : 1'b1);
        t    = in_a ? ftag(kk, pen, nb) : (in_b ? ftag(kk - l, pen, nb) : "R8");
        chk(t, txd, etxd);
        chk("R6", txempty, !busy);
        if (rs) chk((two && tg != 0) ? "R10" : "R7", rts, busy);
        else    chk("R8", rts, sw);
        chk("R5", txrdy, !(two && j > wr_at && j <= l * DIV));
      end
      if (two && j == wr_at) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = {8'd0, b};
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", txrdy, 1);
    chk("R1", txempty, 1);
    chk("R1", txd, 1);
    chk("R1", rts, 0);

    // zero divisor holds the character
    wreg(2'd1, mw(2'd1, 3'd4, 1'b0));
    wreg(2'd0, 16'h005A);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R9", txd, 1);
      chk("R9", txrdy, 0);
      chk("R9", txempty, 0);
      chk("R9", rts, 1);
    end
    wreg(2'd3, DIV);
    repeat (100) @(negedge clk);
    chk("R9", txempty, 1);
    chk("R9", txrdy, 1);

    // vector table, RS485 mode
    for (int v = 0; v < NV; v++) begin
      wreg(2'd1, mw(2'd1, VECS[v].par, 1'b0));
      wreg(2'd2, {8'd0, VECS[v].tg});
      send(VECS[v].data, VECS[v].exp_par, 8'h00, 1'b0, 1'b0, 0,
           VECS[v].par <= 3'd3, int'(VECS[v].tg), 1'b1, 1'b0);
    end

    // back to back, no guard: second frame follows stop bit
    wreg(2'd1, mw(2'd1, 3'd4, 1'b0));
    wreg(2'd2, 16'd0);
    send(8'hC3, 1'b0, 8'h5A, 1'b0, 1'b1, 1, 1'b0, 0, 1'b1, 1'b0);

    // second character queued inside guard period waits for full guard
    wreg(2'd2, 16'd3);
    send(8'h96, 1'b0, 8'h2D, 1'b0, 1'b1, 45, 1'b0, 3, 1'b1, 1'b0);

    // normal mode: rts from mode bit 5, independent of activity
    wreg(2'd2, 16'd0);
    wreg(2'd1, mw(2'd0, 3'd0, 1'b1));
    @(negedge clk);
    chk("R8", rts, 1);
    send(8'hA5, 1'b0, 8'h00, 1'b0, 1'b0, 0, 1'b1, 0, 1'b0, 1'b1);
    wreg(2'd1, mw(2'd0, 3'd1, 1'b0));
    send(8'h3C, 1'b1, 8'h00, 1'b0, 1'b0, 0, 1'b1, 0, 1'b0, 1'b0);

    summary();
  end

endmodule